// File: doc/BRIEF.md
# Command and Response Byte FIFO Controller

This block sits behind a byte-addressed register window of a security module and moves one command and its response through a single shared byte buffer. A host fills the buffer through a data register, one to four bytes per access, and the block reads the total length from the command header to decide when the command is complete. The host then starts execution. The block hands the buffer to a backend through a start/done handshake, and the backend writes its response into the same buffer. The host then drains the response through the same data register, can rewind it with a retry, or can return straight to the ready phase.

A status register reports the phase flags and a burst count that tells the host how many bytes it may move next. Who owns the interface is decided outside the block and arrives as one qualifying input. Aborts and interrupt causes leave the block as one-cycle strobes. Host write data and read data are right-aligned: the first byte of an access sits in bits 7:0.

Top module: `cmdrsp_fifo_ctrl`

## Requirements
- R1: After reset the phase is idle, all status flags are clear, and the status word reads as the family code in bits 27:26 with the burst count in bits 23:8 equal to BUF_BYTES. Status flag positions are: bit7 valid, bit6 command-ready, bit4 data-available, bit3 expect, bit2 self-test-done. Bits 5 (go) and 1 (retry) are write-only and read as 0.
- R2: Writing 0x40 (only command-ready) to byte 0 of the status register while idle moves to ready, sets command-ready and pulses `irq_cmd_ready` for one cycle.
- R3: The first data write while ready moves to reception and leaves the flags at valid and expect. Data writes are dropped while idle, executing or in completion, and while receiving with expect clear.
- R4: Once more than 5 bytes have been received, the 32-bit big-endian length at buffer bytes 2..5 is compared with the received count. Expect stays set while the length exceeds the count and clears when the count reaches it.
- R5: Writing 0x20 (go) during reception with expect clear moves to execution and pulses `be_start` with `be_len` equal to the received byte count. Go is ignored in any other situation. The backend reads the command through `be_rd_addr`/`be_rd_data`.
- R6: A `be_done` pulse during execution enters completion, rewinds the offset to 0, sets valid and data-available, and pulses `irq_sts_valid` and `irq_data_avail`.
- R7: A data read in completion with data-available returns successive response bytes, packed little-endian in the word. When the last byte (response length = header length clamped to BUF_BYTES) has been read, data-available clears, valid stays set and `irq_sts_valid` pulses. Every other data read byte is 0xFF.
- R8: The burst count is the response length minus the offset while data-available is set, and BUF_BYTES minus the offset otherwise. On a one-byte status read it is clamped to 0xFF.
- R9: Writing 0x02 (retry) in completion rewinds the offset and sets valid and data-available again.
- R10: Writing command-ready in completion moves to ready, clears data-available, sets command-ready and pulses `irq_cmd_ready`.
- R11: Writing command-ready during reception pulses `abort_req` and returns at once to ready with command-ready set and an `irq_cmd_ready` pulse. During execution it pulses `abort_req`, and the block stays executing until `be_done`, then enters ready (not completion) and pulses `irq_cmd_ready`.
- R12: Self-test-done is set by `be_done` with `be_selftest_ok` and then stays set until reset. The family bits never change. Every other status update replaces all remaining flags.
- R13: While `host_owns` is low, host accesses change nothing and reads return 0xFFFFFFFF.
- R14: An access uses lane `h_lane` and size `h_size` (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). A data access is clipped at the end of the 32-bit word, and a status read returns the word shifted right by 8×lane and masked to the size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_owns | input | 1 | Host currently owns the interface |
| h_req | input | 1 | Host access strobe |
| h_we | input | 1 | 1 = write, 0 = read |
| h_reg | input | 1 | 0 = status register, 1 = data register |
| h_lane | input | 2 | Starting byte lane in the word |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Right-aligned write data |
| h_rdata | output | 32 | Read data, valid with h_rvalid |
| h_rvalid | output | 1 | Read data returned (cycle after request) |
| be_start | output | 1 | Command issue pulse |
| be_len | output | OFF_W | Command length in bytes |
| be_rd_addr | input | IDX_W | Backend buffer read address |
| be_rd_data | output | 8 | Backend buffer read data |
| be_wr_en | input | 1 | Backend buffer write enable |
| be_wr_addr | input | IDX_W | Backend buffer write address |
| be_wr_data | input | 8 | Backend buffer write data |
| be_done | input | 1 | Response ready pulse |
| be_selftest_ok | input | 1 | Self-test-done report with be_done |
| abort_req | output | 1 | Abort request pulse |
| irq_cmd_ready | output | 1 | Command-ready interrupt cause pulse |
| irq_sts_valid | output | 1 | Status-valid interrupt cause pulse |
| irq_data_avail | output | 1 | Data-available interrupt cause pulse |

## Verification
A wrong phase or byte offset shows up in the burst count of the very next status read, because that count is formed from the offset against either the buffer size or the response length. A wrong flag appears in the low status byte on the next read. A phase error also shows up within one access as a write that is dropped or accepted when it should not be, or as a filler byte where response data was due. A header merged wrongly on the closing write leaves expect set, and go then produces no `be_start` pulse on the following write.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READY = 3'd1,
    PH_RECV  = 3'd2,
    PH_EXEC  = 3'd3,
    PH_COMP  = 3'd4
  } phase_t;

  // host command codes in status byte 0
  localparam logic [7:0] CMD_MASK  = 8'h62;
  localparam logic [7:0] CMD_RDY   = 8'h40;
  localparam logic [7:0] CMD_GO    = 8'h20;
  localparam logic [7:0] CMD_RETRY = 8'h02;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_to_bytes = 3'd1;
      2'd1:    size_to_bytes = 3'd2;
      default: size_to_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cmdrsp_lane.sv
module cmdrsp_lane
  import cmdrsp_pkg::*;
(
  input  logic [1:0] lane,
  input  logic [1:0] size,
  output logic [2:0] n_req,
  output logic [2:0] n_clip
);
  logic [2:0] room;

  always_comb begin
    n_req  = size_to_bytes(size);
    room   = 3'd4 - {1'b0, lane};
    n_clip = (n_req > room) ? room : n_req;
  end
endmodule

// File: rtl/cmdrsp_buffer.sv
module cmdrsp_buffer
  import cmdrsp_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int OFF_W     = 10,
  parameter int IDX_W     = 9
) (
  input  logic             clk,
  input  logic             h_we,
  input  logic [OFF_W-1:0] h_base,
  input  logic [2:0]       h_cnt,
  input  logic [31:0]      h_bytes,
  input  logic [OFF_W-1:0] rd_base,
  output logic [31:0]      rd_bytes,
  output logic [31:0]      hdr_now,
  input  logic             be_we,
  input  logic [IDX_W-1:0] be_waddr,
  input  logic [7:0]       be_wdata,
  input  logic [IDX_W-1:0] be_raddr,
  output logic [7:0]       be_rdata
);
  localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(BUF_BYTES);

  logic [7:0]     mem [BUF_BYTES];
  logic [OFF_W:0] wa  [4];
  logic [OFF_W:0] ra  [4];
  logic [3:0]     wen;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      wa[k]  = {1'b0, h_base} + (OFF_W+1)'(k);
      ra[k]  = {1'b0, rd_base} + (OFF_W+1)'(k);
      wen[k] = h_we && (3'(k) < h_cnt) && (wa[k] < LIMIT);
      rd_bytes[8*k +: 8] = (ra[k] < LIMIT) ? mem[ra[k][IDX_W-1:0]] : FILL_BYTE;
    end
  end

  // storage array: no reset, contents defined by writes
  always_ff @(posedge clk) begin
    if (be_we) begin
      mem[be_waddr] <= be_wdata;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (wen[k]) mem[wa[k][IDX_W-1:0]] <= h_bytes[8*k +: 8];
      end
    end
  end

  assign hdr_now  = {mem[2], mem[3], mem[4], mem[5]};
  assign be_rdata = mem[be_raddr];

endmodule

// File: rtl/cmdrsp_seq.sv
module cmdrsp_seq
  import cmdrsp_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int OFF_W     = 10,
  parameter int FAMILY    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             h_we,
  input  logic             h_reg,
  input  logic [1:0]       h_lane,
  input  logic [2:0]       n_req,
  input  logic [2:0]       n_clip,
  input  logic [31:0]      h_wdata,
  input  logic [31:0]      hdr_now,
  input  logic [31:0]      rd_bytes,
  input  logic             be_done,
  input  logic             be_selftest_ok,
  output logic [OFF_W-1:0] off,
  output logic             buf_we,
  output logic [2:0]       buf_cnt,
  output logic [31:0]      rd_word,
  output logic             be_start,
  output logic [OFF_W-1:0] be_len,
  output logic             abort_req,
  output logic             irq_cmd_ready,
  output logic             irq_sts_valid,
  output logic             irq_data_avail
);
  localparam logic [OFF_W-1:0] BUF_L = OFF_W'(BUF_BYTES);
  localparam logic [1:0]       FAM   = 2'(FAMILY);

  phase_t           state_q, state_d;
  logic [OFF_W-1:0] off_q, off_d, len_q, len_d;
  logic             valid_q, valid_d, cr_q, cr_d, da_q, da_d, ex_q, ex_d;
  logic             st_q, st_d, abort_q, abort_d;
  logic             start_q, start_d, abreq_q, abreq_d;
  logic             icr_q, icr_d, isv_q, isv_d, ida_q, ida_d;

  logic [7:0]       cmd;
  logic             exec_cr;
  logic [OFF_W-1:0] rlen, burst_raw, room, off_new, rd_avail, off_rd;
  logic [15:0]      burst;
  logic [2:0]       nw, nrd;
  logic             ovf;
  logic [31:0]      mhdr, stw, stw_sh, smask;
  logic [7:0]       mb;
  logic [31:0]      data_word;

  // ---------------- derived quantities ----------------
  always_comb begin
    cmd     = (h_lane == 2'd0) ? (h_wdata[7:0] & CMD_MASK) : 8'h00;
    exec_cr = acc && h_we && !h_reg && (cmd == CMD_RDY) && (state_q == PH_EXEC);
    rlen    = (hdr_now > 32'(BUF_BYTES)) ? BUF_L : hdr_now[OFF_W-1:0];

    // burst count
    if (da_q) burst_raw = (rlen > off_q) ? (rlen - off_q) : '0;
    else      burst_raw = BUF_L - off_q;
    if (n_req == 3'd1 && burst_raw > OFF_W'(255)) burst = 16'd255;
    else                                          burst = 16'(burst_raw);

    // host write sizing
    room    = BUF_L - off_q;
    ovf     = OFF_W'(n_clip) > room;
    nw      = ovf ? room[2:0] : n_clip;
    off_new = off_q + OFF_W'(nw);

    // header as it will be after this write
    mhdr = hdr_now;
    for (int i = 0; i < 4; i++) begin
      mb = hdr_now[8*(3-i) +: 8];
      for (int k = 0; k < 4; k++) begin
        if ((32'(off_q) + 32'(k) == 32'(i + 2)) && (3'(k) < nw)) mb = h_wdata[8*k +: 8];
      end
      mhdr[8*(3-i) +: 8] = mb;
    end

    // response read sizing
    rd_avail = (rlen > off_q) ? (rlen - off_q) : OFF_W'(1);
    nrd      = (OFF_W'(n_clip) < rd_avail) ? n_clip : rd_avail[2:0];
    off_rd   = off_q + OFF_W'(nrd);

    // status word
    stw    = {4'b0, FAM, 2'b0, burst, valid_q, cr_q, 1'b0, da_q, ex_q, st_q, 2'b0};
    stw_sh = stw >> {h_lane, 3'b000};
    case (n_req)
      3'd1:    smask = 32'h0000_00FF;
      3'd2:    smask = 32'h0000_FFFF;
      default: smask = 32'hFFFF_FFFF;
    endcase

    // data word
    for (int k = 0; k < 4; k++) begin
      if (3'(k) >= n_clip)                                    data_word[8*k +: 8] = 8'h00;
      else if (state_q == PH_COMP && da_q && 3'(k) < nrd)     data_word[8*k +: 8] = rd_bytes[8*k +: 8];
      else                                                    data_word[8*k +: 8] = FILL_BYTE;
    end

    rd_word = h_reg ? data_word : (stw_sh & smask);
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;  off_d = off_q;  len_d = len_q;
    valid_d = valid_q;  cr_d = cr_q;    da_d = da_q;    ex_d = ex_q;
    st_d    = st_q;     abort_d = abort_q;
    start_d = 1'b0;     abreq_d = 1'b0;
    icr_d   = 1'b0;     isv_d = 1'b0;   ida_d = 1'b0;
    buf_we  = 1'b0;     buf_cnt = nw;

    if (be_done && state_q == PH_EXEC) begin
      off_d = '0;
      if (be_selftest_ok) st_d = 1'b1;
      if (abort_q || exec_cr) begin
        state_d = PH_READY;
        valid_d = 1'b0; cr_d = 1'b1; da_d = 1'b0; ex_d = 1'b0;
        icr_d   = 1'b1;
        abort_d = 1'b0;
        abreq_d = exec_cr;
      end else begin
        state_d = PH_COMP;
        valid_d = 1'b1; cr_d = 1'b0; da_d = 1'b1; ex_d = 1'b0;
        isv_d   = 1'b1; ida_d = 1'b1;
      end
    end else if (acc && h_we && !h_reg) begin
      if (cmd == CMD_RDY) begin
        case (state_q)
          PH_IDLE: begin
            state_d = PH_READY;
            valid_d = 1'b0; cr_d = 1'b1; da_d = 1'b0; ex_d = 1'b0;
            icr_d   = 1'b1;
          end
          PH_READY: off_d = '0;
          PH_RECV: begin
            abreq_d = 1'b1;
            state_d = PH_READY;
            off_d   = '0;
            valid_d = 1'b0; cr_d = 1'b1; da_d = 1'b0; ex_d = 1'b0;
            icr_d   = 1'b1;
          end
          PH_EXEC: begin
            abreq_d = 1'b1;
            abort_d = 1'b1;
          end
          PH_COMP: begin
            state_d = PH_READY;
            off_d   = '0;
            if (!cr_d) begin
              valid_d = 1'b0; cr_d = 1'b1; ex_d = 1'b0;
              icr_d   = 1'b1;
            end
            da_d = 1'b0;
          end
          default: ;
        endcase
      end else if (cmd == CMD_GO) begin
        if (state_q == PH_RECV && !ex_q) begin
          state_d = PH_EXEC;
          start_d = 1'b1;
          len_d   = off_q;
        end
      end else if (cmd == CMD_RETRY) begin
        if (state_q == PH_COMP) begin
          off_d   = '0;
          valid_d = 1'b1; cr_d = 1'b0; da_d = 1'b1; ex_d = 1'b0;
        end
      end
    end else if (acc && h_we && h_reg) begin
      if (state_q == PH_READY || state_q == PH_RECV) begin
        if (state_q == PH_READY) state_d = PH_RECV;
        if (state_q == PH_READY || ex_q) begin
          buf_we  = (nw != 3'd0);
          off_d   = off_new;
          valid_d = 1'b1; cr_d = 1'b0; da_d = 1'b0;
          if (ovf)                       ex_d = 1'b0;
          else if (off_new > OFF_W'(5))  ex_d = (mhdr > 32'(off_new));
          else                           ex_d = 1'b1;
        end
      end
    end else if (acc && !h_we && h_reg) begin
      if (state_q == PH_COMP && da_q) begin
        off_d = off_rd;
        if (off_rd >= rlen) begin
          valid_d = 1'b1; cr_d = 1'b0; da_d = 1'b0; ex_d = 1'b0;
          isv_d   = 1'b1;
        end
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      off_q   <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
      cr_q    <= 1'b0;
      da_q    <= 1'b0;
      ex_q    <= 1'b0;
      st_q    <= 1'b0;
      abort_q <= 1'b0;
      start_q <= 1'b0;
      abreq_q <= 1'b0;
      icr_q   <= 1'b0;
      isv_q   <= 1'b0;
      ida_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      if (start_d) len_q <= len_d;
      valid_q <= valid_d;
      cr_q    <= cr_d;
      da_q    <= da_d;
      ex_q    <= ex_d;
      st_q    <= st_d;
      abort_q <= abort_d;
      start_q <= start_d;
      abreq_q <= abreq_d;
      icr_q   <= icr_d;
      isv_q   <= isv_d;
      ida_q   <= ida_d;
    end
  end

  assign off            = off_q;
  assign be_start       = start_q;
  assign be_len         = len_q;
  assign abort_req      = abreq_q;
  assign irq_cmd_ready  = icr_q;
  assign irq_sts_valid  = isv_q;
  assign irq_data_avail = ida_q;

  // ---------------- assertions ----------------
  a_r3_expect_only_receiving: assert property (@(posedge clk) disable iff (!rst_n)
    ex_q |-> (state_q == PH_RECV));
  a_r6_avail_only_completion: assert property (@(posedge clk) disable iff (!rst_n)
    da_q |-> (state_q == PH_COMP));
  a_r5_start_has_header: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (len_q > OFF_W'(5)));
  a_r7_offset_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= BUF_L);
  a_r6_done_leaves_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_EXEC && be_done) |=> (state_q == PH_COMP || state_q == PH_READY));
  a_r11_abort_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (state_q == PH_EXEC));
  a_r12_selftest_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |=> st_q);

endmodule

// File: rtl/cmdrsp_fifo_ctrl.sv
module cmdrsp_fifo_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int FAMILY    = 1,
  parameter int OFF_W     = $clog2(BUF_BYTES + 1),
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_owns,
  input  logic             h_req,
  input  logic             h_we,
  input  logic             h_reg,
  input  logic [1:0]       h_lane,
  input  logic [1:0]       h_size,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_rdata,
  output logic             h_rvalid,
  output logic             be_start,
  output logic [OFF_W-1:0] be_len,
  input  logic [IDX_W-1:0] be_rd_addr,
  output logic [7:0]       be_rd_data,
  input  logic             be_wr_en,
  input  logic [IDX_W-1:0] be_wr_addr,
  input  logic [7:0]       be_wr_data,
  input  logic             be_done,
  input  logic             be_selftest_ok,
  output logic             abort_req,
  output logic             irq_cmd_ready,
  output logic             irq_sts_valid,
  output logic             irq_data_avail
);
  logic             acc, rd_acc;
  logic [2:0]       n_req, n_clip, buf_cnt;
  logic [OFF_W-1:0] off;
  logic             buf_we;
  logic [31:0]      rd_bytes, hdr_now, rd_word, rdata_q;
  logic             rvalid_q;

  assign acc    = h_req & host_owns;
  assign rd_acc = h_req & ~h_we;

  cmdrsp_lane u_lane (
    .lane   (h_lane),
    .size   (h_size),
    .n_req  (n_req),
    .n_clip (n_clip)
  );

  cmdrsp_buffer #(.BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_buf (
    .clk      (clk),
    .h_we     (buf_we),
    .h_base   (off),
    .h_cnt    (buf_cnt),
    .h_bytes  (h_wdata),
    .rd_base  (off),
    .rd_bytes (rd_bytes),
    .hdr_now  (hdr_now),
    .be_we    (be_wr_en),
    .be_waddr (be_wr_addr),
    .be_wdata (be_wr_data),
    .be_raddr (be_rd_addr),
    .be_rdata (be_rd_data)
  );

  cmdrsp_seq #(.BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W), .FAMILY(FAMILY)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc            (acc),
    .h_we           (h_we),
    .h_reg          (h_reg),
    .h_lane         (h_lane),
    .n_req          (n_req),
    .n_clip         (n_clip),
    .h_wdata        (h_wdata),
    .hdr_now        (hdr_now),
    .rd_bytes       (rd_bytes),
    .be_done        (be_done),
    .be_selftest_ok (be_selftest_ok),
    .off            (off),
    .buf_we         (buf_we),
    .buf_cnt        (buf_cnt),
    .rd_word        (rd_word),
    .be_start       (be_start),
    .be_len         (be_len),
    .abort_req      (abort_req),
    .irq_cmd_ready  (irq_cmd_ready),
    .irq_sts_valid  (irq_sts_valid),
    .irq_data_avail (irq_data_avail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= host_owns ? rd_word : 32'hFFFF_FFFF;
    end
  end

  assign h_rdata  = rdata_q;
  assign h_rvalid = rvalid_q;

  a_r13_foreign_read_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we && !host_owns) |=> (h_rvalid && h_rdata == 32'hFFFF_FFFF));
  a_r14_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> $past(h_req && !h_we));

endmodule

// File: tb/sim_cmdrsp_fifo_ctrl.sv
module sim_cmdrsp_fifo_ctrl;
  localparam int CLK_P = 10;
  localparam int BUF   = 512;
  localparam int OW    = $clog2(BUF + 1);
  localparam int IW    = $clog2(BUF);

  logic clk, rst_n, host_owns, h_req, h_we, h_reg;
  logic [1:0] h_lane, h_size;
  logic [31:0] h_wdata, h_rdata;
  logic h_rvalid, be_start, be_wr_en, be_done, be_selftest_ok;
  logic [OW-1:0] be_len;
  logic [IW-1:0] be_rd_addr, be_wr_addr;
  logic [7:0] be_rd_data, be_wr_data;
  logic abort_req, irq_cmd_ready, irq_sts_valid, irq_data_avail;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  cmdrsp_fifo_ctrl #(.BUF_BYTES(BUF), .FAMILY(1)) u0 (.*);

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [31:0] sw(input logic [7:0] bits, input int burst);
    return 32'h0400_0000 | (32'(burst) << 8) | 32'(bits);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic hwrite(input logic r, input logic [1:0] ln, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    h_req = 1; h_we = 1; h_reg = r; h_lane = ln; h_size = sz; h_wdata = d;
    @(negedge clk);
    h_req = 0; h_we = 0;
  endtask

  task automatic hread(input logic r, input logic [1:0] ln, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    h_req = 1; h_we = 0; h_reg = r; h_lane = ln; h_size = sz;
    @(negedge clk);
    h_req = 0;
    d = h_rdata;
  endtask

  task automatic sts(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    hread(0, 2'd0, 2'd2, v);
    check(tag, v, exp);
  endtask

  task automatic finish_cmd(input logic st);
    @(negedge clk);
    be_done = 1; be_selftest_ok = st;
    @(negedge clk);
    be_done = 0; be_selftest_ok = 0;
  endtask

  task automatic t_reset;
    check("R1 rvalid idle", 32'(h_rvalid), 0);
    check("R1 no strobes", {28'd0, be_start, abort_req, irq_cmd_ready, irq_sts_valid}, 0);
    sts("R1 reset status", sw(8'h00, BUF));
  endtask

  task automatic t_foreign;
    logic [31:0] v;
    host_owns = 0;
    hwrite(0, 2'd0, 2'd0, 32'h40);
    check("R13 no irq when foreign", 32'(irq_cmd_ready), 0);
    hread(0, 2'd0, 2'd2, v);
    check("R13 foreign read", v, 32'hFFFF_FFFF);
    host_owns = 1;
    sts("R13 state untouched", sw(8'h00, BUF));
  endtask

  task automatic t_idle_drop;
    hwrite(1, 2'd0, 2'd2, 32'h1234_5678);
    hwrite(0, 2'd0, 2'd0, 32'h20);
    check("R5 go ignored in idle", 32'(be_start), 0);
    sts("R3 idle data dropped", sw(8'h00, BUF));
  endtask

  task automatic t_ready;
    logic [31:0] v;
    hwrite(0, 2'd0, 2'd0, 32'h40);
    check("R2 cmd-ready irq", 32'(irq_cmd_ready), 1);
    sts("R2 ready status", sw(8'h40, BUF));
    hread(0, 2'd1, 2'd0, v);
    check("R8 one-byte clamp", v, 32'hFF);
    hread(0, 2'd1, 2'd1, v);
    check("R14 two-byte status lane1", v, 32'h0200);
  endtask

  task automatic t_send;
    logic [31:0] v;
    hwrite(1, 2'd0, 2'd2, 32'h0000_0180);
    sts("R3 reception entered", sw(8'h88, BUF-4));
    hwrite(1, 2'd0, 2'd1, 32'h0000_0A00);
    sts("R4 expect held", sw(8'h88, BUF-6));
    hwrite(1, 2'd2, 2'd2, 32'hFFFF_2211);
    sts("R14 clipped write", sw(8'h88, BUF-8));
    hwrite(1, 2'd0, 2'd1, 32'h0000_4433);
    sts("R4 packet complete", sw(8'h80, BUF-10));
    hwrite(1, 2'd0, 2'd0, 32'h55);
    sts("R3 drop after complete", sw(8'h80, BUF-10));
    hwrite(0, 2'd0, 2'd0, 32'h20);
    check("R5 start pulse", 32'(be_start), 1);
    check("R5 length", 32'(be_len), 10);
    be_rd_addr = 5;
    #1 check("R5 backend header byte", 32'(be_rd_data), 32'h0A);
    be_rd_addr = 9;
    #1 check("R5 backend last byte", 32'(be_rd_data), 32'h44);
    hwrite(1, 2'd0, 2'd2, 32'hDEAD_BEEF);
    sts("R3 exec data dropped", sw(8'h80, BUF-10));
    hread(1, 2'd0, 2'd2, v);
    check("R7 filler while executing", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_response;
    logic [31:0] v;
    logic [7:0] rsp [12];
    rsp = '{8'hC4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0C, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      be_wr_en = 1; be_wr_addr = IW'(i); be_wr_data = rsp[i];
    end
    @(negedge clk);
    be_wr_en = 0;
    finish_cmd(1);
    check("R6 sts-valid irq", 32'(irq_sts_valid), 1);
    check("R6 data-avail irq", 32'(irq_data_avail), 1);
    sts("R6 R12 completion status", sw(8'h94, 12));
    hread(0, 2'd1, 2'd0, v);
    check("R8 response burst", v, 12);
    hread(1, 2'd0, 2'd1, v);
    check("R7 first bytes", v, 32'h0000_00C4);
    sts("R8 burst after read", sw(8'h94, 10));
    hwrite(0, 2'd0, 2'd0, 32'h02);
    sts("R9 retry rewinds", sw(8'h94, 12));
    hread(1, 2'd0, 2'd2, v);
    check("R7 word0", v, 32'h0000_00C4);
    hread(1, 2'd0, 2'd2, v);
    check("R7 word1", v, 32'hA2A1_0C00);
    hread(1, 2'd0, 2'd2, v);
    check("R7 word2", v, 32'hA6A5_A4A3);
    check("R7 last-byte irq", 32'(irq_sts_valid), 1);
    sts("R7 drained status", sw(8'h84, BUF-12));
    hread(1, 2'd0, 2'd2, v);
    check("R7 filler after end", v, 32'hFFFF_FFFF);
    hwrite(0, 2'd0, 2'd0, 32'h02);
    sts("R9 retry after drain", sw(8'h94, 12));
    hwrite(0, 2'd0, 2'd0, 32'h40);
    check("R10 cmd-ready irq", 32'(irq_cmd_ready), 1);
    sts("R10 shortcut to ready", sw(8'h44, BUF));
  endtask

  task automatic t_abort_recv;
    hwrite(1, 2'd0, 2'd2, 32'h0000_0180);
    sts("R3 reception again", sw(8'h8C, BUF-4));
    hwrite(0, 2'd0, 2'd0, 32'h40);
    check("R11 abort pulse recv", 32'(abort_req), 1);
    check("R11 irq recv", 32'(irq_cmd_ready), 1);
    sts("R11 ready after abort", sw(8'h44, BUF));
  endtask

  task automatic t_abort_exec;
    hwrite(1, 2'd0, 2'd2, 32'h0000_0180);
    hwrite(1, 2'd0, 2'd1, 32'h0000_0600);
    sts("R4 six-byte packet", sw(8'h84, BUF-6));
    hwrite(0, 2'd0, 2'd0, 32'h20);
    check("R5 short length", 32'(be_len), 6);
    hwrite(0, 2'd0, 2'd0, 32'h40);
    check("R11 abort pulse exec", 32'(abort_req), 1);
    check("R11 no irq yet", 32'(irq_cmd_ready), 0);
    sts("R11 still executing", sw(8'h84, BUF-6));
    finish_cmd(0);
    check("R11 irq on done", 32'(irq_cmd_ready), 1);
    check("R11 no data irq", 32'(irq_data_avail), 0);
    sts("R11 R12 ready with self-test kept", sw(8'h44, BUF));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 got=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; host_owns = 1; h_req = 0; h_we = 0; h_reg = 0; h_lane = 0; h_size = 0;
    h_wdata = 0; be_rd_addr = 0; be_wr_en = 0; be_wr_addr = 0; be_wr_data = 0;
    be_done = 0; be_selftest_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_foreign;
    t_idle_drop;
    t_ready;
    t_send;
    t_response;
    t_abort_recv;
    t_abort_exec;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule